// File: doc/BRIEF.md
# Register-Bank I2C Target with Post-Write Clock Stretching

This block is a two-wire serial target that holds a small bank of byte-wide registers, the kind of layout a clock or calendar peripheral uses. It watches the open-drain clock and data lines through synchronizers. It drives them only through low-enable outputs, so the pad logic or the bench resolves each line as a wired-AND. A host addresses it with a fixed 7-bit device address. In a write transfer the first byte after the address loads a register pointer, and each later byte is stored at the pointer. In a read transfer the byte at the pointer is shifted out, and the pointer advances after every byte in either direction.

Once a transfer that wrote data ends, the target models a slow internal commit with a countdown timer. If the host addresses the target again before the count expires, the target holds the clock low in the low phase that follows the address byte. It releases the clock when the count runs out, and the transfer then continues at the host's own pace.

Top module: `i2c_regbank_target`

## Requirements
- R1: A start condition (SDA falling while SCL is high) begins reception of an address byte from any state. A stop condition (SDA rising while SCL is high) returns the target to idle. Clock pulses that arrive after a stop and before the next start draw no acknowledge.
- R2: The address byte carries 7 address bits MSB first, followed by a direction bit (0 = write, 1 = read). When the 7 bits equal DEV_ADDR, the target holds SDA low for the whole ninth clock.
- R3: When the address does not match, the target sends no acknowledge and keeps SDA released until the next start or stop. No byte sent in that transfer changes any register.
- R4: In a write transfer, the byte after the address sets the pointer to that value modulo NREGS. Every later byte is stored at the pointer. Each of these bytes is acknowledged.
- R5: In a read transfer, the target drives the byte at the pointer MSB first, starting in the low phase after the address acknowledge. It releases SDA during the ninth clock. A host acknowledge (SDA low) makes it send the next register. A host not-acknowledge (SDA high) makes it release SDA until the next start or stop.
- R6: The pointer advances by one after every data byte, written or read, and wraps from NREGS-1 to 0.
- R7: The target changes its SDA drive only while the synchronized SCL is low. It captures incoming bits on SCL rising edges.
- R8: A stop or repeated start that ends a transfer in which data was written loads the busy counter with BUSY_CYCLES. The counter then drops by one every clock until it reaches zero.
- R9: While the busy counter is non-zero, and the target has matched its address in the current transfer, it holds SCL low in any low phase. It releases SCL when the count expires, and the transfer then completes normally. A non-matching transfer, or a transfer after the count has expired, is never stretched.
- R10: After reset, both low-enable outputs are released and the busy counter is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Resolved level of the serial clock line |
| sda_i | input | 1 | Resolved level of the serial data line |
| scl_low_o | output | 1 | Pull the clock line low when 1 |
| sda_low_o | output | 1 | Pull the data line low when 1 |

## Verification
A wrong pointer or a corrupted register shows up as a bad byte on the next read, within the nine clocks of the first data byte. A transfer state that has slipped by one bit shows up sooner, as an acknowledge missing from or added to the ninth clock of the current byte. A busy counter that was never loaded, or that never clears, shows up at the address acknowledge of the following transfer, as a stretch that is missing or that never ends. SDA drive while SCL is high is caught on the clock it happens.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACK_SETUP,
    ST_ACK,
    ST_TX,
    ST_MACK,
    ST_MACK_WAIT,
    ST_IGNORE
  } tgt_state_e;

  typedef enum logic [1:0] {
    BY_ADDR,
    BY_PTR,
    BY_DATA
  } byte_kind_e;

  typedef struct packed {
    logic scl;
    logic sda;
    logic scl_rise;
    logic scl_fall;
    logic start;
    logic stop;
  } bus_evt_t;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  scl_i,
  input  logic                  sda_i,
  output i2c_tgt_pkg::bus_evt_t evt
);

  logic [STAGES-1:0] scl_pipe;
  logic [STAGES-1:0] sda_pipe;
  logic              scl_q;
  logic              sda_q;
  logic              scl_now;
  logic              sda_now;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_q    <= scl_pipe[STAGES-1];
      sda_q    <= sda_pipe[STAGES-1];
    end
  end

  assign scl_now = scl_pipe[STAGES-1];
  assign sda_now = sda_pipe[STAGES-1];

  always_comb begin
    evt.scl      = scl_now;
    evt.sda      = sda_now;
    evt.scl_rise = scl_now & ~scl_q;
    evt.scl_fall = ~scl_now & scl_q;
    evt.start    = scl_now & scl_q & sda_q & ~sda_now;
    evt.stop     = scl_now & scl_q & ~sda_q & sda_now;
  end

endmodule

// File: rtl/i2c_busy_timer.sv
module i2c_busy_timer #(
  parameter int BUSY_CYCLES = 1000,
  localparam int CW = $clog2(BUSY_CYCLES + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  output logic          busy,
  output logic [CW-1:0] count
);

  always_ff @(posedge clk) begin
    if (rst)
      count <= '0;
    else if (load)
      count <= CW'(BUSY_CYCLES);
    else if (count != '0)
      count <= count - 1'b1;
  end

  assign busy = (count != '0);

endmodule

// File: rtl/i2c_reg_bank.sv
module i2c_reg_bank #(
  parameter int NREGS = 8,
  parameter int DW    = 8,
  localparam int AW   = (NREGS > 1) ? $clog2(NREGS) : 1
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] mem [NREGS];

  always_ff @(posedge clk) begin
    if (we)
      mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/i2c_regbank_target.sv
module i2c_regbank_target #(
  parameter logic [6:0] DEV_ADDR    = 7'h3A,
  parameter int         NREGS       = 8,
  parameter int         BUSY_CYCLES = 1000,
  parameter int         SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_low_o,
  output logic sda_low_o
);

  localparam int PTR_W = (NREGS > 1) ? $clog2(NREGS) : 1;
  localparam int CW    = $clog2(BUSY_CYCLES + 1);

  i2c_tgt_pkg::bus_evt_t   evt;
  i2c_tgt_pkg::tgt_state_e state;
  i2c_tgt_pkg::byte_kind_e kind;

  logic [3:0]       bitcnt;
  logic [7:0]       shreg;
  logic [7:0]       byte_now;
  logic [7:0]       txbuf;
  logic [7:0]       rdata;
  logic [PTR_W-1:0] ptr;
  logic [PTR_W-1:0] ptr_next;
  logic             is_read;
  logic             dirty;
  logic             busy;
  logic [CW-1:0]    busy_cnt;
  logic             busy_load;
  logic             we;
  logic             engaged;
  logic             scl_sync;
  logic             st_idle;
  logic             st_ignore;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst   (rst),
    .scl_i (scl_i),
    .sda_i (sda_i),
    .evt   (evt)
  );

  i2c_busy_timer #(.BUSY_CYCLES(BUSY_CYCLES)) u_busy (
    .clk   (clk),
    .rst   (rst),
    .load  (busy_load),
    .busy  (busy),
    .count (busy_cnt)
  );

  i2c_reg_bank #(.NREGS(NREGS), .DW(8)) u_bank (
    .clk   (clk),
    .we    (we),
    .waddr (ptr),
    .wdata (byte_now),
    .raddr (ptr),
    .rdata (rdata)
  );

  assign byte_now  = {shreg[6:0], evt.sda};
  assign ptr_next  = (ptr == PTR_W'(NREGS - 1)) ? '0 : ptr + 1'b1;
  assign busy_load = (evt.start | evt.stop) & dirty;
  assign scl_sync  = evt.scl;
  assign st_idle   = (state == i2c_tgt_pkg::ST_IDLE);
  assign st_ignore = (state == i2c_tgt_pkg::ST_IGNORE);

  // a register write lands on the eighth rising edge of a data byte
  assign we = (state == i2c_tgt_pkg::ST_RX) && (kind == i2c_tgt_pkg::BY_DATA) &&
              evt.scl_rise && (bitcnt == 4'd7) && !evt.start && !evt.stop;

  // the target counts as engaged once its own address has been matched
  always_comb begin
    case (state)
      i2c_tgt_pkg::ST_ACK_SETUP,
      i2c_tgt_pkg::ST_ACK,
      i2c_tgt_pkg::ST_TX,
      i2c_tgt_pkg::ST_MACK,
      i2c_tgt_pkg::ST_MACK_WAIT: engaged = 1'b1;
      i2c_tgt_pkg::ST_RX:        engaged = (kind != i2c_tgt_pkg::BY_ADDR);
      default:                   engaged = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= i2c_tgt_pkg::ST_IDLE;
      kind      <= i2c_tgt_pkg::BY_ADDR;
      bitcnt    <= '0;
      shreg     <= '0;
      txbuf     <= '0;
      ptr       <= '0;
      is_read   <= 1'b0;
      dirty     <= 1'b0;
      sda_low_o <= 1'b0;
      scl_low_o <= 1'b0;
    end else begin
      scl_low_o <= busy && !evt.scl && engaged;

      if (busy_load)
        dirty <= 1'b0;
      else if (we)
        dirty <= 1'b1;

      if (evt.stop) begin
        state     <= i2c_tgt_pkg::ST_IDLE;
        sda_low_o <= 1'b0;
      end else if (evt.start) begin
        state     <= i2c_tgt_pkg::ST_RX;
        kind      <= i2c_tgt_pkg::BY_ADDR;
        bitcnt    <= '0;
        sda_low_o <= 1'b0;
      end else begin
        case (state)
          i2c_tgt_pkg::ST_RX: begin
            if (evt.scl_rise) begin
              shreg <= byte_now;
              if (bitcnt == 4'd7) begin
                bitcnt <= '0;
                case (kind)
                  i2c_tgt_pkg::BY_ADDR: begin
                    if (byte_now[7:1] == DEV_ADDR) begin
                      is_read <= byte_now[0];
                      state   <= i2c_tgt_pkg::ST_ACK_SETUP;
                    end else begin
                      state   <= i2c_tgt_pkg::ST_IGNORE;
                    end
                  end
                  i2c_tgt_pkg::BY_PTR: begin
                    ptr   <= PTR_W'(byte_now % NREGS);
                    state <= i2c_tgt_pkg::ST_ACK_SETUP;
                  end
                  default: begin
                    ptr   <= ptr_next;
                    state <= i2c_tgt_pkg::ST_ACK_SETUP;
                  end
                endcase
              end else begin
                bitcnt <= bitcnt + 1'b1;
              end
            end
          end

          i2c_tgt_pkg::ST_ACK_SETUP: begin
            if (evt.scl_fall) begin
              sda_low_o <= 1'b1;
              state     <= i2c_tgt_pkg::ST_ACK;
            end
          end

          i2c_tgt_pkg::ST_ACK: begin
            if (evt.scl_fall) begin
              bitcnt <= '0;
              if (kind == i2c_tgt_pkg::BY_ADDR && is_read) begin
                txbuf     <= rdata;
                sda_low_o <= ~rdata[7];
                state     <= i2c_tgt_pkg::ST_TX;
              end else begin
                sda_low_o <= 1'b0;
                state     <= i2c_tgt_pkg::ST_RX;
                kind      <= (kind == i2c_tgt_pkg::BY_ADDR) ? i2c_tgt_pkg::BY_PTR
                                                            : i2c_tgt_pkg::BY_DATA;
              end
            end
          end

          i2c_tgt_pkg::ST_TX: begin
            if (evt.scl_rise) begin
              if (bitcnt == 4'd7)
                ptr <= ptr_next;
              bitcnt <= bitcnt + 1'b1;
            end else if (evt.scl_fall) begin
              if (bitcnt == 4'd8) begin
                sda_low_o <= 1'b0;
                state     <= i2c_tgt_pkg::ST_MACK;
              end else begin
                sda_low_o <= ~txbuf[6];
                txbuf     <= {txbuf[6:0], 1'b0};
              end
            end
          end

          i2c_tgt_pkg::ST_MACK: begin
            if (evt.scl_rise)
              state <= evt.sda ? i2c_tgt_pkg::ST_IGNORE : i2c_tgt_pkg::ST_MACK_WAIT;
          end

          i2c_tgt_pkg::ST_MACK_WAIT: begin
            if (evt.scl_fall) begin
              txbuf     <= rdata;
              sda_low_o <= ~rdata[7];
              bitcnt    <= '0;
              state     <= i2c_tgt_pkg::ST_TX;
            end
          end

          default: begin
            sda_low_o <= 1'b0;
          end
        endcase
      end
    end
  end

endmodule

// File: rtl/i2c_regbank_target_chk.sv
module i2c_regbank_target_chk #(
  parameter int NREGS       = 8,
  parameter int BUSY_CYCLES = 1000,
  localparam int PTR_W      = (NREGS > 1) ? $clog2(NREGS) : 1,
  localparam int CW         = $clog2(BUSY_CYCLES + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic             scl_sync,
  input logic             sda_low_o,
  input logic             scl_low_o,
  input logic             busy,
  input logic             busy_load,
  input logic [CW-1:0]    busy_cnt,
  input logic [PTR_W-1:0] ptr,
  input logic             st_idle,
  input logic             st_ignore,
  input i2c_tgt_pkg::bus_evt_t evt
);

  // R7
  sda_edge_chk: assert property (@(posedge clk) disable iff (rst)
    (sda_low_o != $past(sda_low_o)) |-> !scl_sync);

  // R9
  stretch_busy_chk: assert property (@(posedge clk) disable iff (rst)
    scl_low_o |-> $past(busy));

  // R3
  ignore_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    st_ignore |-> !sda_low_o);

  // R1
  stop_idle_chk: assert property (@(posedge clk) disable iff (rst)
    evt.stop |=> st_idle);

  // R6
  ptr_range_chk: assert property (@(posedge clk) disable iff (rst)
    ptr <= PTR_W'(NREGS - 1));

  // R8
  busy_count_chk: assert property (@(posedge clk) disable iff (rst)
    (busy_cnt != '0 && !busy_load) |=> busy_cnt == $past(busy_cnt) - 1'b1);

  // R8
  busy_load_chk: assert property (@(posedge clk) disable iff (rst)
    busy_load |=> busy_cnt == CW'(BUSY_CYCLES));

endmodule

bind i2c_regbank_target i2c_regbank_target_chk #(
  .NREGS(NREGS),
  .BUSY_CYCLES(BUSY_CYCLES)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .scl_sync  (scl_sync),
  .sda_low_o (sda_low_o),
  .scl_low_o (scl_low_o),
  .busy      (busy),
  .busy_load (busy_load),
  .busy_cnt  (busy_cnt),
  .ptr       (ptr),
  .st_idle   (st_idle),
  .st_ignore (st_ignore),
  .evt       (evt)
);

// File: tb/i2c_regbank_target_tb.sv
module i2c_regbank_target_tb;

  localparam logic [6:0] ADDR   = 7'h3A;
  localparam int         NR     = 8;
  localparam int         BUSY   = 1000;
  localparam int         HP     = 20;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic m_scl = 1'b1;
  logic m_sda = 1'b1;
  logic scl_bus, sda_bus;
  logic scl_low_o, sda_low_o;

  always #4 clk = ~clk;

  assign scl_bus = m_scl & ~scl_low_o;
  assign sda_bus = m_sda & ~sda_low_o;

  i2c_regbank_target #(
    .DEV_ADDR(ADDR), .NREGS(NR), .BUSY_CYCLES(BUSY), .SYNC_STAGES(2)
  ) u_dut (
    .clk(clk), .rst(rst), .scl_i(scl_bus), .sda_i(sda_bus),
    .scl_low_o(scl_low_o), .sda_low_o(sda_low_o)
  );

  int n_tests = 0;
  int n_fail  = 0;
  int stretch_cyc = 0;
  logic [7:0] model [NR];
  int mptr = 0;

  // per-clock reference expectations
  logic quiet = 1'b0;
  logic no_stretch = 1'b0;
  int   mon_quiet_err = 0;
  int   mon_stretch_err = 0;
  int   mon_edge_err = 0;
  logic prev_sda_low = 1'b0;
  logic prev_scl = 1'b1;

  always @(negedge clk) begin
    if (!rst) begin
      if (quiet && sda_low_o) mon_quiet_err++;
      if (no_stretch && scl_low_o) mon_stretch_err++;
      if (sda_low_o != prev_sda_low && scl_bus && prev_scl) mon_edge_err++;
    end
    prev_sda_low = sda_low_o;
    prev_scl     = scl_bus;
  end

  task automatic check(input string tag, input int act, input int exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic scl_high();
    m_scl = 1'b1;
    @(negedge clk);
    while (scl_bus == 1'b0) begin
      stretch_cyc++;
      @(negedge clk);
    end
  endtask

  task automatic do_start();
    m_sda = 1'b1; wclk(HP);
    scl_high();   wclk(HP);
    m_sda = 1'b0; wclk(HP);
    m_scl = 1'b0; wclk(4);
  endtask

  task automatic do_stop();
    m_sda = 1'b0; wclk(HP);
    scl_high();   wclk(HP);
    m_sda = 1'b1; wclk(HP);
  endtask

  task automatic wr_byte(input logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; wclk(HP);
      scl_high();   wclk(HP);
      m_scl = 1'b0; wclk(4);
    end
    m_sda = 1'b1; wclk(HP);
    scl_high();   wclk(HP);
    acked = (sda_bus == 1'b0);
    m_scl = 1'b0; wclk(4);
  endtask

  task automatic rd_byte(input logic ack, output logic [7:0] b);
    m_sda = 1'b1;
    b = '0;
    for (int i = 0; i < 8; i++) begin
      wclk(HP);
      scl_high(); wclk(HP);
      b = {b[6:0], sda_bus};
      m_scl = 1'b0; wclk(4);
    end
    m_sda = ~ack; wclk(HP);
    scl_high();   wclk(HP);
    m_scl = 1'b0; wclk(4);
    m_sda = 1'b1;
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic       a;
    logic [7:0] d;

    wclk(5);
    rst = 1'b0;
    wclk(3);
    // R10: released lines after reset
    check("R10 scl released", scl_low_o, 0);
    check("R10 sda released", sda_low_o, 0);

    // write pointer 3, data 11 22 33 with no stretch (busy idle)
    no_stretch = 1'b1;
    stretch_cyc = 0;
    do_start();
    wr_byte({ADDR, 1'b0}, a); check("R2 address ack on write", a, 1);
    wr_byte(8'h03, a);        check("R4 pointer byte ack", a, 1);
    mptr = 3;
    wr_byte(8'h11, a); check("R4 data ack 0", a, 1); model[mptr] = 8'h11; mptr = (mptr + 1) % NR;
    wr_byte(8'h22, a); check("R4 data ack 1", a, 1); model[mptr] = 8'h22; mptr = (mptr + 1) % NR;
    wr_byte(8'h33, a); check("R4 data ack 2", a, 1); model[mptr] = 8'h33; mptr = (mptr + 1) % NR;
    do_stop();
    no_stretch = 1'b0;
    check("R9 no stretch while idle", stretch_cyc, 0);

    // R8/R9: immediate new transfer is stretched at its address ack
    stretch_cyc = 0;
    do_start();
    wr_byte({ADDR, 1'b0}, a); check("R2 address ack while busy", a, 1);
    check("R9 stretch occurred", (stretch_cyc > 0) ? 1 : 0, 1);
    check("R8 stretch bounded by busy count", (stretch_cyc < BUSY) ? 1 : 0, 1);
    wr_byte(8'h03, a); check("R4 pointer reload ack", a, 1);
    mptr = 3;
    do_start();
    wr_byte({ADDR, 1'b1}, a); check("R2 address ack on read", a, 1);
    rd_byte(1'b1, d); check("R5 read byte 0", d, model[mptr]); mptr = (mptr + 1) % NR;
    rd_byte(1'b1, d); check("R6 read autoincrement", d, model[mptr]); mptr = (mptr + 1) % NR;
    rd_byte(1'b0, d); check("R5 read byte 2", d, model[mptr]); mptr = (mptr + 1) % NR;
    quiet = 1'b1;
    wclk(HP);
    check("R5 sda released after host nack", sda_low_o, 0);
    do_stop();

    // R1: clocks after a stop and without a start draw no ack
    wr_byte(8'h74, a); check("R1 no ack without start", a, 0);
    quiet = 1'b0;
    do_stop();

    // R3: non-matching address
    do_start();
    quiet = 1'b1;
    wr_byte({ADDR ^ 7'h01, 1'b0}, a); check("R3 mismatch no ack", a, 0);
    wr_byte(8'h03, a); check("R3 ignored pointer", a, 0);
    wr_byte(8'h99, a); check("R3 ignored data", a, 0);
    quiet = 1'b0;
    do_stop();
    do_start();
    wr_byte({ADDR, 1'b0}, a);
    wr_byte(8'h03, a);
    do_start();
    wr_byte({ADDR, 1'b1}, a);
    rd_byte(1'b0, d); check("R3 register untouched", d, 8'h11);
    do_stop();

    // R6 wrap: pointer 7, two bytes land at 7 and 0
    do_start();
    wr_byte({ADDR, 1'b0}, a);
    wr_byte(8'h07, a);
    mptr = 7;
    wr_byte(8'h77, a); model[mptr] = 8'h77; mptr = (mptr + 1) % NR;
    wr_byte(8'h88, a); check("R6 write after wrap acked", a, 1); model[mptr] = 8'h88;
    do_stop();

    // R9: mismatch while busy is never stretched
    no_stretch = 1'b1;
    quiet = 1'b1;
    stretch_cyc = 0;
    do_start();
    wr_byte({ADDR ^ 7'h10, 1'b1}, a); check("R3 mismatch read no ack", a, 0);
    quiet = 1'b0;
    do_stop();
    check("R9 no stretch on mismatch", stretch_cyc, 0);

    // R9: after busy expires, no stretch
    wclk(BUSY + 200);
    stretch_cyc = 0;
    do_start();
    wr_byte({ADDR, 1'b0}, a);
    wr_byte(8'h07, a);
    do_start();
    wr_byte({ADDR, 1'b1}, a);
    rd_byte(1'b1, d); check("R6 read at last register", d, 8'h77);
    rd_byte(1'b0, d); check("R6 read wraps to register 0", d, 8'h88);
    do_stop();
    check("R9 no stretch after expiry", stretch_cyc, 0);
    no_stretch = 1'b0;

    // R4: pointer value above bank size is taken modulo NREGS (0x0B -> 3)
    do_start();
    wr_byte({ADDR, 1'b0}, a);
    wr_byte(8'h0B, a); check("R4 large pointer acked", a, 1);
    do_start();
    wr_byte({ADDR, 1'b1}, a);
    rd_byte(1'b0, d); check("R4 pointer modulo bank size", d, 8'h11);
    do_stop();

    wclk(50);
    check("R3 quiet monitor", mon_quiet_err, 0);
    check("R9 stretch monitor", mon_stretch_err, 0);
    check("R7 sda edge monitor", mon_edge_err, 0);
    finish_run();
  end

endmodule